// File: doc/BRIEF.md
# Zero-Overhead Loop and Branch Sequencer

This block produces the fetch address for a pipelined signal-processing core. Each cycle it takes decoded control signals that describe the instruction sitting at the current fetch address. It then picks the next address: the next one in sequence, the same one again, the first address of a hardware loop, or a branch target. Loops cost no instruction cycles. When the fetch address reaches the end of an active loop body, the sequencer goes straight back to the first address of the body. One shared repeat counter, loaded by software before the loop starts, decides how many passes are made. A second repeat form re-issues a single instruction by holding the fetch address.

There are two kinds of branch. A delayed branch, whether conditional or not, lets the three instructions after it be fetched and executed. Only then does the program counter move to the latched target, or carry on in sequence if the condition was false. A standard taken branch clears the pipeline instead. It raises a flush request for three cycles while the address is frozen, so the target is fetched four cycles after the branch. A branch decoded inside the slots of a delayed branch is dropped and flagged.

Top module: `loop_branch_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, `fetch_addr` becomes `RESET_ADDR` (0 by default), and `flush`, `hold` and `nest_err` become 0.
- R2: With no control input asserted, `fetch_addr` increases by one on every clock edge.
- R3: A taken standard branch (`dec_br`=1, `dec_cond`=1) decoded at address A keeps `fetch_addr` at A and `flush` at 1 for the next three cycles. `dec_target` is then fetched in the fourth cycle after the branch. If `dec_cond`=0, fetching continues at A+1 with no flush.
- R4: Every control input is ignored in a cycle where `flush` is 1.
- R5: A delayed branch (`dec_br_dly`=1) decoded at address A fetches A+1, A+2 and A+3 in order. It then fetches `dec_target` if `dec_cond` was 1, or A+4 if it was 0. `flush` stays 0 throughout.
- R6: A standard or delayed branch decoded at one of the three slot addresses of a delayed branch has no effect. `nest_err` is 1 for exactly the following cycle.
- R7: After a count load (`dec_cnt_ld`) of N, a block repeat decoded at A with end address E fetches A+1 through E N+1 times in a row, then E+1.
- R8: After a count load of N, a single repeat decoded at A presents A+1 for N+1 consecutive cycles, with `hold`=1 in the first N of them, then A+2. Control inputs are ignored during these cycles.
- R9: When the last slot of a delayed branch falls on the block end address, the branch target is fetched next rather than the loop start.
- R10: A taken standard branch located at the block end address overrides the loop-back and raises `flush` as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dec_rpt_blk | input | 1 | Block repeat decoded at the current address |
| dec_blk_end | input | AW | Last address of the loop body |
| dec_rpt_one | input | 1 | Single-instruction repeat decoded |
| dec_br | input | 1 | Standard branch decoded |
| dec_br_dly | input | 1 | Delayed branch decoded |
| dec_target | input | AW | Branch target address |
| dec_cond | input | 1 | Branch condition is true |
| dec_cnt_ld | input | 1 | Load the repeat counter |
| dec_cnt_val | input | CW | Value loaded into the repeat counter |
| fetch_addr | output | AW | Current fetch address |
| flush | output | 1 | Pipeline flush request |
| hold | output | 1 | Address held for single repeat |
| nest_err | output | 1 | Branch in delayed slots was dropped |

## Verification
Two redirect sources can compete for the same cycle: the end of a loop body and the resolution of a branch. The bench provokes this twice. In the first case it places a delayed branch so that its third slot is the block end address. In the second it puts a taken standard branch exactly at the end address. In each case the recorded address sequence must go to the branch target and never back to the loop start, and the flush pattern must match R3 for the standard branch.

// File: rtl/seq_pkg.sv
// Shared definitions for the fetch-address sequencer.
// Assumes nothing beyond a single clock domain.
package seq_pkg;
    // Source of the next fetch address, highest priority first.
    typedef enum logic [1:0] {
        PC_JUMP = 2'd0,
        PC_HOLD = 2'd1,
        PC_LOOP = 2'd2,
        PC_SEQ  = 2'd3
    } pc_sel_e;
endpackage

// File: rtl/seq_branch.sv
// Branch control: delayed branches with SLOTS always-executed slots, and
// standard branches that freeze fetch and raise flush for FLUSH cycles.
// Assumes decoded inputs describe the instruction at the current address and
// that the upstream caller deasserts `accept` while a single repeat runs.
module seq_branch #(
    parameter int unsigned AW    = 16,
    parameter int unsigned SLOTS = 3,
    parameter int unsigned FLUSH = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          br,
    input  logic          br_dly,
    input  logic          cond,
    input  logic [AW-1:0] target,
    output logic          redirect,
    output logic [AW-1:0] redir_addr,
    output logic          freeze,
    output logic          flush,
    output logic          nest_err
);
    localparam int unsigned SW = $clog2(SLOTS + 1);
    localparam int unsigned FW = $clog2(FLUSH + 1);

    logic [SW-1:0] slot_cnt;
    logic [FW-1:0] fl_cnt;
    logic [AW-1:0] tgt_q;
    logic          take_q;
    logic          err_q;
    logic          in_slots, in_flush, ok, go_std, go_dly, nest;

    // Decode which branch request is honoured this cycle.
    always_comb begin
        in_slots = (slot_cnt != '0);
        in_flush = (fl_cnt != '0);
        ok       = accept && !in_flush;
        go_dly   = ok && !in_slots && br_dly;
        go_std   = ok && !in_slots && br && cond && !br_dly;
        nest     = ok && in_slots && (br || br_dly);
    end

    // Slot and flush counters, latched target, error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_cnt <= '0;
            fl_cnt   <= '0;
            tgt_q    <= '0;
            take_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            err_q <= nest;
            if (go_std || go_dly) begin
                tgt_q  <= target;
                take_q <= go_dly ? cond : 1'b1;
            end
            if (go_std)        fl_cnt <= FW'(FLUSH);
            else if (in_flush) fl_cnt <= fl_cnt - FW'(1);
            if (go_dly)        slot_cnt <= SW'(SLOTS);
            else if (in_slots) slot_cnt <= slot_cnt - SW'(1);
        end
    end

    // Redirect after the last flush cycle or the last delayed slot.
    always_comb begin
        redirect   = (fl_cnt == FW'(1)) || ((slot_cnt == SW'(1)) && take_q);
        redir_addr = tgt_q;
        freeze     = go_std || in_flush;
        flush      = in_flush;
        nest_err   = err_q;
    end

    // R4
    excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({in_flush, in_slots}));
    // R3
    flush_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go_std |=> flush);
    // R6
    nest_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nest_err |-> $past(in_slots));
endmodule

// File: rtl/seq_repeat.sv
// Repeat control: one shared count register used by block repeat (loop back
// to the body start at the end address) and by single repeat (hold address).
// Assumes the caller deasserts `accept` during flush and single repeat, and
// that `br_busy` marks cycles in which a branch owns the next address.
module seq_repeat #(
    parameter int unsigned AW = 16,
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic [AW-1:0] pc,
    input  logic          rpt_blk,
    input  logic [AW-1:0] blk_end,
    input  logic          rpt_one,
    input  logic          cnt_ld,
    input  logic [CW-1:0] cnt_val,
    input  logic          br_busy,
    output logic          loop_back,
    output logic [AW-1:0] blk_start,
    output logic          sgl_act,
    output logic          hold
);
    logic [CW-1:0] cnt;
    logic [AW-1:0] start_q, last_q;
    logic          blk_act, sgl_q, at_end, cnt_zero, blk_go;

    // Loop-end detection and single-repeat hold.
    always_comb begin
        cnt_zero  = (cnt == '0);
        at_end    = blk_act && !sgl_q && !br_busy && (pc == last_q);
        loop_back = at_end && !cnt_zero;
        hold      = sgl_q && !cnt_zero;
        blk_go    = accept && rpt_blk;
        blk_start = start_q;
        sgl_act   = sgl_q;
    end

    // Repeat counter: load wins over decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt <= '0;
        else if (accept && cnt_ld)   cnt <= cnt_val;
        else if (loop_back || hold)  cnt <= cnt - CW'(1);
    end

    // Block loop bounds and activity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_act <= 1'b0;
            start_q <= '0;
            last_q  <= '0;
        end else if (blk_go) begin
            blk_act <= 1'b1;
            start_q <= pc + AW'(1);
            last_q  <= blk_end;
        end else if (at_end && cnt_zero) begin
            blk_act <= 1'b0;
        end
    end

    // Single-repeat activity.
    always_ff @(posedge clk) begin
        if (!rst_n)                   sgl_q <= 1'b0;
        else if (accept && rpt_one)   sgl_q <= 1'b1;
        else if (sgl_q && cnt_zero)   sgl_q <= 1'b0;
    end

    // R7
    loop_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (at_end && cnt_zero && !blk_go) |=> !blk_act);
    // R8
    hold_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> sgl_act);
endmodule

// File: rtl/loop_branch_seq.sv
// Fetch-address sequencer top: combines branch and repeat control and owns
// the program counter. Assumes decoded inputs describe the instruction at
// `fetch_addr` in the same cycle, and that only one of them is set at a time.
module loop_branch_seq #(
    parameter int unsigned AW         = 16,
    parameter int unsigned CW         = 16,
    parameter int unsigned SLOTS      = 3,
    parameter int unsigned FLUSH      = 3,
    parameter logic [AW-1:0] RESET_ADDR = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dec_rpt_blk,
    input  logic [AW-1:0] dec_blk_end,
    input  logic          dec_rpt_one,
    input  logic          dec_br,
    input  logic          dec_br_dly,
    input  logic [AW-1:0] dec_target,
    input  logic          dec_cond,
    input  logic          dec_cnt_ld,
    input  logic [CW-1:0] dec_cnt_val,
    output logic [AW-1:0] fetch_addr,
    output logic          flush,
    output logic          hold,
    output logic          nest_err
);
    import seq_pkg::*;

    logic [AW-1:0] pc, redir_addr, blk_start, pc_nxt;
    logic          redirect, freeze, loop_back, sgl_act, br_flush, rpt_hold;
    pc_sel_e       sel;

    seq_branch #(.AW(AW), .SLOTS(SLOTS), .FLUSH(FLUSH)) u_br (
        .clk(clk), .rst_n(rst_n), .accept(!sgl_act),
        .br(dec_br), .br_dly(dec_br_dly), .cond(dec_cond), .target(dec_target),
        .redirect(redirect), .redir_addr(redir_addr), .freeze(freeze),
        .flush(br_flush), .nest_err(nest_err)
    );

    seq_repeat #(.AW(AW), .CW(CW)) u_rpt (
        .clk(clk), .rst_n(rst_n), .accept(!sgl_act && !br_flush), .pc(pc),
        .rpt_blk(dec_rpt_blk), .blk_end(dec_blk_end), .rpt_one(dec_rpt_one),
        .cnt_ld(dec_cnt_ld), .cnt_val(dec_cnt_val),
        .br_busy(redirect || freeze),
        .loop_back(loop_back), .blk_start(blk_start),
        .sgl_act(sgl_act), .hold(rpt_hold)
    );

    // Choose the next-address source by priority.
    always_comb begin
        if (redirect)               sel = PC_JUMP;
        else if (freeze || rpt_hold) sel = PC_HOLD;
        else if (loop_back)         sel = PC_LOOP;
        else                        sel = PC_SEQ;
        case (sel)
            PC_JUMP: pc_nxt = redir_addr;
            PC_HOLD: pc_nxt = pc;
            PC_LOOP: pc_nxt = blk_start;
            default: pc_nxt = pc + AW'(1);
        endcase
    end

    // Program counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) pc <= RESET_ADDR;
        else        pc <= pc_nxt;
    end

    // Drive the outputs.
    always_comb begin
        fetch_addr = pc;
        flush      = br_flush;
        hold       = rpt_hold;
    end

    // R3
    flush_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> $stable(fetch_addr));
    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(fetch_addr));
    // R7
    loop_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loop_back |=> (fetch_addr == $past(blk_start)));
endmodule

// File: tb/sim_loop_branch_seq.sv
`timescale 1ns/1ps
module sim_loop_branch_seq;
    localparam int AW = 16;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          dec_rpt_blk, dec_rpt_one, dec_br, dec_br_dly, dec_cond, dec_cnt_ld;
    logic [AW-1:0] dec_blk_end, dec_target;
    logic [CW-1:0] dec_cnt_val;
    logic [AW-1:0] fetch_addr;
    logic          flush, hold, nest_err;
    int            total = 0;
    int            bad = 0;

    always #10 clk = ~clk;

    loop_branch_seq #(.AW(AW), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .dec_rpt_blk(dec_rpt_blk), .dec_blk_end(dec_blk_end),
        .dec_rpt_one(dec_rpt_one), .dec_br(dec_br), .dec_br_dly(dec_br_dly),
        .dec_target(dec_target), .dec_cond(dec_cond), .dec_cnt_ld(dec_cnt_ld),
        .dec_cnt_val(dec_cnt_val), .fetch_addr(fetch_addr), .flush(flush),
        .hold(hold), .nest_err(nest_err)
    );

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic clr();
        dec_rpt_blk = 0; dec_rpt_one = 0; dec_br = 0; dec_br_dly = 0;
        dec_cond = 0; dec_cnt_ld = 0; dec_blk_end = '0; dec_target = '0;
        dec_cnt_val = '0;
    endtask

    task automatic do_reset();
        clr();
        rst_n = 0;
        tick(); tick();
        rst_n = 1;
    endtask

    task automatic goto(input int a);
        for (int i = 0; i < 200 && fetch_addr != AW'(a); i++) tick();
    endtask

    task automatic load_cnt(input int n);
        dec_cnt_ld = 1; dec_cnt_val = CW'(n);
        tick(); clr();
    endtask

    // R1, R2
    task automatic t_reset_seq();
        do_reset();
        chk("R1 addr", fetch_addr, 0);
        chk("R1 flush", flush, 0);
        chk("R1 hold", hold, 0);
        chk("R1 err", nest_err, 0);
        for (int i = 1; i <= 4; i++) begin
            tick();
            chk("R2 seq", fetch_addr, i);
        end
    endtask

    // R3, R4
    task automatic t_std_branch();
        do_reset();
        goto(5);
        dec_br = 1; dec_cond = 1; dec_target = 40;
        tick(); clr();
        for (int i = 0; i < 3; i++) begin
            chk("R3 flush on", flush, 1);
            chk("R3 addr held", fetch_addr, 5);
            if (i == 1) begin
                dec_br_dly = 1; dec_cond = 1; dec_target = 99;
            end
            tick(); clr();
        end
        chk("R3 flush off", flush, 0);
        chk("R3 target", fetch_addr, 40);
        for (int i = 1; i <= 5; i++) begin
            tick();
            chk("R4 ignored in flush", fetch_addr, 40 + i);
        end
        dec_br = 1; dec_cond = 0; dec_target = 70;
        tick(); clr();
        chk("R3 not taken addr", fetch_addr, 46);
        chk("R3 not taken flush", flush, 0);
    endtask

    // R5, R6
    task automatic t_dly_branch();
        do_reset();
        goto(10);
        dec_br_dly = 1; dec_cond = 1; dec_target = 60;
        tick(); clr();
        chk("R5 slot1", fetch_addr, 11);
        dec_br_dly = 1; dec_cond = 1; dec_target = 80;
        tick(); clr();
        chk("R5 slot2", fetch_addr, 12);
        chk("R6 err pulse", nest_err, 1);
        tick();
        chk("R5 slot3", fetch_addr, 13);
        chk("R6 err cleared", nest_err, 0);
        chk("R5 no flush", flush, 0);
        tick();
        chk("R5 target", fetch_addr, 60);
        for (int i = 1; i <= 4; i++) begin
            tick();
            chk("R6 nested dropped", fetch_addr, 60 + i);
        end
        goto(70);
        dec_br_dly = 1; dec_cond = 0; dec_target = 20;
        tick(); clr();
        for (int i = 1; i <= 4; i++) begin
            chk("R5 false cond", fetch_addr, 70 + i);
            tick();
        end
    endtask

    // R7
    task automatic t_block(input int n);
        do_reset();
        goto(3);
        load_cnt(n);
        dec_rpt_blk = 1; dec_blk_end = 7;
        tick(); clr();
        for (int i = 0; i <= (n + 1) * 3; i++) begin
            chk("R7 block addr", fetch_addr, (i < (n + 1) * 3) ? 5 + (i % 3) : 8);
            chk("R7 no flush", flush, 0);
            tick();
        end
    endtask

    // R8
    task automatic t_single();
        do_reset();
        goto(3);
        load_cnt(2);
        dec_rpt_one = 1;
        tick(); clr();
        chk("R8 addr a", fetch_addr, 5);
        chk("R8 hold a", hold, 1);
        dec_br = 1; dec_cond = 1; dec_target = 90;
        tick();
        chk("R8 addr b", fetch_addr, 5);
        chk("R8 hold b", hold, 1);
        tick();
        chk("R8 addr c", fetch_addr, 5);
        chk("R8 hold c", hold, 0);
        tick(); clr();
        chk("R8 after", fetch_addr, 6);
        chk("R8 no flush", flush, 0);
        tick();
        chk("R8 ignored branch", fetch_addr, 7);
    endtask

    // R9
    task automatic t_dly_at_end();
        do_reset();
        goto(2);
        load_cnt(3);
        dec_rpt_blk = 1; dec_blk_end = 9;
        tick(); clr();
        goto(6);
        dec_br_dly = 1; dec_cond = 1; dec_target = 50;
        tick(); clr();
        for (int i = 7; i <= 9; i++) begin
            chk("R9 slots", fetch_addr, i);
            tick();
        end
        chk("R9 branch wins", fetch_addr, 50);
        tick();
        chk("R9 continues", fetch_addr, 51);
    endtask

    // R10
    task automatic t_std_at_end();
        do_reset();
        goto(2);
        load_cnt(3);
        dec_rpt_blk = 1; dec_blk_end = 6;
        tick(); clr();
        goto(6);
        dec_br = 1; dec_cond = 1; dec_target = 30;
        tick(); clr();
        for (int i = 0; i < 3; i++) begin
            chk("R10 flush", flush, 1);
            chk("R10 held", fetch_addr, 6);
            tick();
        end
        chk("R10 target", fetch_addr, 30);
        tick();
        chk("R10 continues", fetch_addr, 31);
    endtask

    initial begin
        #(20 * 100000);
        bad++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        clr();
        rst_n = 0;
        t_reset_seq();
        t_std_branch();
        t_dly_branch();
        t_block(2);
        t_block(0);
        t_single();
        t_dly_at_end();
        t_std_at_end();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule